// File: doc/BRIEF.md
# Multifunction Pin Control Router

This block turns a bank of general-purpose input pins into the internal control signals of a clock synchronizer. Each pin owns a 7-bit function code, loaded through a parallel write port, that names the control target the pin drives. The targets are the holdover and free-run mode requests, the three incremental phase offset commands (reset, step up, step down), per-reference monitor overrides and forced validation timeouts, the four output enables with an enable-all code, and a distribution sync request.

Pins pass through a two-flop synchronizer before they are decoded. When two or more pins name the same target, the pin with the smallest index drives it and the others are ignored. Level targets come out as registered levels. Command targets come out as one-cycle pulses on the rising edge of the routed level. Straight after reset, the synchronized pin levels are captured once into a strap word so that start-up configuration logic can read it. Later pin activity does not change that word until the next reset.

Top module: `mfp_router`

## Requirements
- R1: While rst_n is low and after it rises, every function code is 0, every level and pulse output is 0, and strap_valid and strap_cfg are 0.
- R2: A clock edge with cfg_we high loads cfg_code into the code slot of pin cfg_sel. Other slots keep their codes.
- R3: Code 16 routes the pin to mode_holdover and code 17 routes it to mode_freerun. A pin change shows on the output after the third rising clock edge.
- R4: Codes 32 to 39 drive mon_override[code-32], and codes 48 to 55 drive timeout_force[code-48]. Bit 0 is reference A, followed by AA, B, BB, C, CC, D and DD up to bit 7.
- R5: Codes 64 to 67 drive out_enable[code-64]. Code 68 drives all four bits. Each bit is the OR of its own routed level and the routed enable-all level.
- R6: Code 18 (phase_reset_pulse), 19 (phase_inc_pulse), 20 (phase_dec_pulse) and 69 (dist_sync_pulse) each give a pulse exactly one cycle long when the routed level rises. Holding the pin high gives no further pulse.
- R7: When several pins carry the same code, the lowest-indexed of them alone drives the target, even when that pin is low and a higher one is high.
- R8: Codes 0 to 15, 21 to 31, 40 to 47, 56 to 63 and 70 to 127 drive nothing. A target that no pin selects stays 0.
- R9: On the third rising edge after rst_n rises, the synchronized pins are captured into strap_cfg (bit i is pin i) and strap_valid goes high. Both then hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Code slot write enable |
| cfg_sel | input | 3 | Pin whose code slot is written |
| cfg_code | input | 7 | Function code to load |
| pins_in | input | 8 | Asynchronous pin levels |
| mode_holdover | output | 1 | Holdover request level |
| mode_freerun | output | 1 | Free-run request level |
| phase_reset_pulse | output | 1 | Phase offset reset command |
| phase_inc_pulse | output | 1 | Phase offset step-up command |
| phase_dec_pulse | output | 1 | Phase offset step-down command |
| mon_override | output | 8 | Reference monitor override levels |
| timeout_force | output | 8 | Forced validation timeout levels |
| out_enable | output | 4 | Clock output enables |
| dist_sync_pulse | output | 1 | Distribution sync command |
| strap_cfg | output | 8 | Pin levels captured after reset |
| strap_valid | output | 1 | strap_cfg has been captured |

## Verification
All 128 codes are loaded in turn into a rotating pin slot. The other pins hold code 0 and every pin is driven high, so a single sweep covers the decode of every code, every pulse target, every slot and the silence of unused codes. Each code is checked with its pin low, on the rising edge and while held high, which separates level targets from pulse targets and a single pulse from a stretched one. Every pair of pins carrying the same code is driven with the low pin off and the high pin on, then the reverse, which shows whether the lowest index wins regardless of the pin's value. Further tests cover enable OR-ing with code 68, conflicts on the enable-all code, and strap capture across two resets with different pin words.

// File: rtl/mfp_pkg.sv
// Package mfp_pkg
// Shared constants, target numbering and the function-code decoder of the
// pin router. The target numbering is internal; only the code values and the
// reference/output ordering inside a group are behaviour.
package mfp_pkg;
    localparam int CODE_W   = 7;
    localparam int NUM_REF  = 8;
    localparam int NUM_OUT  = 4;

    // internal target numbering
    localparam int TGT_HOLD  = 0;
    localparam int TGT_FREE  = 1;
    localparam int TGT_PRST  = 2;
    localparam int TGT_PINC  = 3;
    localparam int TGT_PDEC  = 4;
    localparam int TGT_MON0  = 5;
    localparam int TGT_TMO0  = TGT_MON0 + NUM_REF;
    localparam int TGT_OEN0  = TGT_TMO0 + NUM_REF;
    localparam int TGT_OEALL = TGT_OEN0 + NUM_OUT;
    localparam int TGT_SYNC  = TGT_OEALL + 1;
    localparam int NUM_TGT   = TGT_SYNC + 1;
    localparam int TGT_W     = $clog2(NUM_TGT);

    // code group bases
    localparam int CODE_HOLD = 16;
    localparam int CODE_PRST = 18;
    localparam int CODE_MON  = 32;
    localparam int CODE_TMO  = 48;
    localparam int CODE_OEN  = 64;
    localparam int CODE_SYNC = CODE_OEN + NUM_OUT + 1;

    typedef struct packed {
        logic             hit;
        logic [TGT_W-1:0] idx;
    } tgt_sel_t;

    // Map one function code to a target; hit is 0 for unused codes.
    function automatic tgt_sel_t decode_code(input logic [CODE_W-1:0] code);
        tgt_sel_t s;
        int c;
        c = int'(code);
        s.hit = 1'b0;
        s.idx = '0;
        if (c >= CODE_HOLD && c < CODE_PRST) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_HOLD + (c - CODE_HOLD));
        end else if (c >= CODE_PRST && c < CODE_PRST + 3) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_PRST + (c - CODE_PRST));
        end else if (c >= CODE_MON && c < CODE_MON + NUM_REF) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_MON0 + (c - CODE_MON));
        end else if (c >= CODE_TMO && c < CODE_TMO + NUM_REF) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_TMO0 + (c - CODE_TMO));
        end else if (c >= CODE_OEN && c <= CODE_OEN + NUM_OUT) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_OEN0 + (c - CODE_OEN));
        end else if (c == CODE_SYNC) begin
            s.hit = 1'b1;
            s.idx = TGT_W'(TGT_SYNC);
        end
        return s;
    endfunction
endpackage

// File: rtl/mfp_code_regs.sv
// Module mfp_code_regs
// Holds one function code per pin, loaded through a parallel write port.
// Assumes sel < NUM_PINS; a larger sel writes nothing. Reset clears all codes.
module mfp_code_regs
    import mfp_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = $clog2(NUM_PINS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [SEL_W-1:0]                   sel,
    input  logic [CODE_W-1:0]                  code_in,
    output logic [NUM_PINS-1:0][CODE_W-1:0]    codes
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
        // Load slot p when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[p] <= '0;
            else if (we && sel == SEL_W'(p))
                codes[p] <= code_in;
        end
    end
endmodule

// File: rtl/mfp_sync.sv
// Module mfp_sync
// Multi-stage flop synchronizer for asynchronous pin levels. Assumes
// STAGES >= 1; the output lags the input by STAGES rising edges.
module mfp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pin levels one stage down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mfp_route.sv
// Module mfp_route
// Decodes every pin's function code and resolves conflicts: for each target
// the lowest-indexed pin that selects it supplies the level. A target that
// no pin selects reads 0. Purely combinational.
module mfp_route
    import mfp_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0][CODE_W-1:0] codes,
    input  logic [NUM_PINS-1:0]             pin_lvl,
    output logic [NUM_TGT-1:0]              tgt_lvl
);
    tgt_sel_t [NUM_PINS-1:0] sel;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
        // Decode the code of pin p.
        assign sel[p] = decode_code(codes[p]);
    end

    // Scan pins from the highest index down so the lowest match is kept.
    always_comb begin
        tgt_lvl = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            for (int p = NUM_PINS - 1; p >= 0; p--) begin
                if (sel[p].hit && sel[p].idx == TGT_W'(t))
                    tgt_lvl[t] = pin_lvl[p];
            end
        end
    end
endmodule

// File: rtl/mfp_edge_stage.sv
// Module mfp_edge_stage
// Registers the routed target levels and produces a one-cycle rise flag per
// target. Assumes the input is already synchronous to clk.
module mfp_edge_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] lvl_q,
    output logic [WIDTH-1:0] rise_q
);
    // Hold the level and flag where it went from 0 to 1 this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            rise_q <= '0;
        end else begin
            lvl_q  <= lvl_in;
            rise_q <= lvl_in & ~lvl_q;
        end
    end
endmodule

// File: rtl/mfp_router.sv
// Module mfp_router
// Top of the multifunction pin router: code slots, pin synchronizer,
// priority routing, edge stage and one-shot strap capture after reset.
// Assumes pins_in is asynchronous and rst_n is synchronous to clk.
module mfp_router
    import mfp_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic [NUM_PINS-1:0] pins_in,
    output logic                mode_holdover,
    output logic                mode_freerun,
    output logic                phase_reset_pulse,
    output logic                phase_inc_pulse,
    output logic                phase_dec_pulse,
    output logic [NUM_REF-1:0]  mon_override,
    output logic [NUM_REF-1:0]  timeout_force,
    output logic [NUM_OUT-1:0]  out_enable,
    output logic                dist_sync_pulse,
    output logic [NUM_PINS-1:0] strap_cfg,
    output logic                strap_valid
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1) + 1;

    logic [NUM_PINS-1:0][CODE_W-1:0] code_q;
    logic [NUM_PINS-1:0]             pin_s;
    logic [NUM_TGT-1:0]              tgt_lvl;
    logic [NUM_TGT-1:0]              tgt_q;
    logic [NUM_TGT-1:0]              tgt_rise;
    logic [CNT_W-1:0]                strap_cnt;

    mfp_code_regs #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .code_in (cfg_code),
        .codes   (code_q)
    );

    mfp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (pin_s)
    );

    mfp_route #(.NUM_PINS(NUM_PINS)) u_route (
        .codes   (code_q),
        .pin_lvl (pin_s),
        .tgt_lvl (tgt_lvl)
    );

    mfp_edge_stage #(.WIDTH(NUM_TGT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (tgt_lvl),
        .lvl_q  (tgt_q),
        .rise_q (tgt_rise)
    );

    // Count edges since reset and capture the strap word once the chain is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_cnt   <= '0;
            strap_cfg   <= '0;
            strap_valid <= 1'b0;
        end else if (!strap_valid) begin
            if (strap_cnt == CNT_W'(SYNC_STAGES)) begin
                strap_cfg   <= pin_s;
                strap_valid <= 1'b1;
            end else begin
                strap_cnt <= strap_cnt + 1'b1;
            end
        end
    end

    // Map registered levels and rise flags onto the named outputs.
    assign mode_holdover     = tgt_q[TGT_HOLD];
    assign mode_freerun      = tgt_q[TGT_FREE];
    assign phase_reset_pulse = tgt_rise[TGT_PRST];
    assign phase_inc_pulse   = tgt_rise[TGT_PINC];
    assign phase_dec_pulse   = tgt_rise[TGT_PDEC];
    assign dist_sync_pulse   = tgt_rise[TGT_SYNC];
    assign mon_override      = tgt_q[TGT_MON0 +: NUM_REF];
    assign timeout_force     = tgt_q[TGT_TMO0 +: NUM_REF];

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_oen
        // Each enable is its own routed level or the enable-all level.
        assign out_enable[o] = tgt_q[TGT_OEN0 + o] | tgt_q[TGT_OEALL];
    end
endmodule

// File: rtl/mfp_router_chk.sv
// Module mfp_router_chk
// Property checker for mfp_router, attached by the bind below. Watches the
// code slots and the output ports.
module mfp_router_chk
    import mfp_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_PINS-1:0][CODE_W-1:0] code_q,
    input logic                            mode_holdover,
    input logic                            mode_freerun,
    input logic                            phase_reset_pulse,
    input logic                            phase_inc_pulse,
    input logic                            phase_dec_pulse,
    input logic [NUM_REF-1:0]              mon_override,
    input logic [NUM_REF-1:0]              timeout_force,
    input logic [NUM_OUT-1:0]              out_enable,
    input logic                            dist_sync_pulse,
    input logic [NUM_PINS-1:0]             strap_cfg,
    input logic                            strap_valid
);
    logic any_func;
    logic any_func_q;

    // Flag whether any slot holds a code that drives a target.
    always_comb begin
        any_func = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if ((code_q[p] >= 7'd16 && code_q[p] <= 7'd20) ||
                (code_q[p] >= 7'd32 && code_q[p] <= 7'd39) ||
                (code_q[p] >= 7'd48 && code_q[p] <= 7'd55) ||
                (code_q[p] >= 7'd64 && code_q[p] <= 7'd69))
                any_func = 1'b1;
        end
    end

    // Delay the flag to line up with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) any_func_q <= 1'b0;
        else        any_func_q <= any_func;
    end

    AST_QUIET_WHEN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !any_func_q |-> (!mode_holdover && !mode_freerun && mon_override == '0 &&
                         timeout_force == '0 && out_enable == '0 && !phase_reset_pulse &&
                         !phase_inc_pulse && !phase_dec_pulse && !dist_sync_pulse)); // R8
    AST_INC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_inc_pulse |=> !phase_inc_pulse); // R6
    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dist_sync_pulse |=> !dist_sync_pulse); // R6
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        strap_valid |=> (strap_valid && $stable(strap_cfg))); // R9
    AST_STRAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_valid |-> strap_cfg == '0); // R9
endmodule

bind mfp_router mfp_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .code_q            (code_q),
    .mode_holdover     (mode_holdover),
    .mode_freerun      (mode_freerun),
    .phase_reset_pulse (phase_reset_pulse),
    .phase_inc_pulse   (phase_inc_pulse),
    .phase_dec_pulse   (phase_dec_pulse),
    .mon_override      (mon_override),
    .timeout_force     (timeout_force),
    .out_enable        (out_enable),
    .dist_sync_pulse   (dist_sync_pulse),
    .strap_cfg         (strap_cfg),
    .strap_valid       (strap_valid)
);

// File: tb/mfp_router_test.sv
// Bench for mfp_router: reset, strap capture, full code sweep, priority pairs.
module mfp_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_sel;
    logic [6:0] cfg_code;
    logic [7:0] pins_in;
    logic       mode_holdover, mode_freerun;
    logic       phase_reset_pulse, phase_inc_pulse, phase_dec_pulse, dist_sync_pulse;
    logic [7:0] mon_override, timeout_force, strap_cfg;
    logic [3:0] out_enable;
    logic       strap_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    mfp_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_code(cfg_code), .pins_in(pins_in),
        .mode_holdover(mode_holdover), .mode_freerun(mode_freerun),
        .phase_reset_pulse(phase_reset_pulse), .phase_inc_pulse(phase_inc_pulse),
        .phase_dec_pulse(phase_dec_pulse), .mon_override(mon_override),
        .timeout_force(timeout_force), .out_enable(out_enable),
        .dist_sync_pulse(dist_sync_pulse), .strap_cfg(strap_cfg),
        .strap_valid(strap_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // levels: [21] holdover [20] freerun [19:12] mon [11:4] timeout [3:0] enable
    function automatic logic [21:0] lv_now();
        return {mode_holdover, mode_freerun, mon_override, timeout_force, out_enable};
    endfunction
    // pulses: [3] reset [2] inc [1] dec [0] sync
    function automatic logic [3:0] pv_now();
        return {phase_reset_pulse, phase_inc_pulse, phase_dec_pulse, dist_sync_pulse};
    endfunction

    function automatic logic [21:0] exp_lv(input int c);
        logic [21:0] v = '0;
        if (c == 16) v[21] = 1'b1;
        if (c == 17) v[20] = 1'b1;
        if (c >= 32 && c <= 39) v[12 + c - 32] = 1'b1;
        if (c >= 48 && c <= 55) v[4 + c - 48] = 1'b1;
        if (c >= 64 && c <= 67) v[c - 64] = 1'b1;
        if (c == 68) v[3:0] = 4'hF;
        return v;
    endfunction
    function automatic logic [3:0] exp_pv(input int c);
        logic [3:0] v = '0;
        if (c == 18) v[3] = 1'b1;
        if (c == 19) v[2] = 1'b1;
        if (c == 20) v[1] = 1'b1;
        if (c == 69) v[0] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int slot, input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(slot); cfg_code = 7'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] strap);
        @(negedge clk);
        rst_n = 1'b0; pins_in = strap; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 levels in reset", 32'(lv_now()), 32'h0);
        chk("R1 pulses in reset", 32'(pv_now()), 32'h0);
        chk("R1 strap in reset", {23'h0, strap_valid, strap_cfg}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 strap not yet valid", 32'(strap_valid), 32'h0);
        @(negedge clk);
        chk("R9 strap captured", {23'h0, strap_valid, strap_cfg}, {23'h0, 1'b1, strap});
        pins_in = ~strap;
        repeat (4) @(negedge clk);
        chk("R9 strap held", {23'h0, strap_valid, strap_cfg}, {23'h0, 1'b1, strap});
        chk("R1 codes cleared, no output", 32'(lv_now()), 32'h0);
        pins_in = 8'h00;
        settle();
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_code = '0; pins_in = 8'h00;
        do_reset(8'hA5);

        // R2 R3 R4 R5 R6 R8: sweep all codes through rotating slots
        for (int c = 0; c < 128; c++) begin
            wr(c % 8, c);
            settle();
            chk("R8 pins low", 32'({lv_now(), pv_now()}), 32'h0);
            pins_in = 8'hFF;
            settle();
            chk($sformatf("R3 R4 R5 R8 level code %0d", c), 32'(lv_now()), 32'(exp_lv(c)));
            chk($sformatf("R6 pulse code %0d", c), 32'(pv_now()), 32'(exp_pv(c)));
            @(negedge clk);
            chk($sformatf("R6 pulse ends code %0d", c), 32'(pv_now()), 32'h0);
            chk($sformatf("R2 level held code %0d", c), 32'(lv_now()), 32'(exp_lv(c)));
            pins_in = 8'h00;
            settle();
            wr(c % 8, 0);
        end

        // R7: every pin pair shares code 16
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                wr(i, 16); wr(j, 16);
                pins_in = 8'(1 << j);
                settle();
                chk($sformatf("R7 low pin %0d wins off", i), 32'(mode_holdover), 32'h0);
                pins_in = 8'(1 << i);
                settle();
                chk($sformatf("R7 low pin %0d wins on", i), 32'(mode_holdover), 32'h1);
                pins_in = 8'h00;
                wr(i, 0); wr(j, 0);
                settle();
            end
        end

        // R5: enable OR and enable-all conflicts
        wr(0, 64); wr(1, 68);
        pins_in = 8'b0000_0010; settle();
        chk("R5 enable-all", 32'(out_enable), 32'hF);
        pins_in = 8'b0000_0001; settle();
        chk("R5 single enable", 32'(out_enable), 32'h1);
        pins_in = 8'b0000_0011; settle();
        chk("R5 OR of both", 32'(out_enable), 32'hF);
        wr(2, 68); wr(3, 68); wr(0, 0); wr(1, 0);
        pins_in = 8'b0000_1000; settle();
        chk("R7 enable-all lower pin low", 32'(out_enable), 32'h0);
        pins_in = 8'b0000_0100; settle();
        chk("R7 enable-all lower pin high", 32'(out_enable), 32'hF);
        pins_in = 8'h00;

        do_reset(8'h3C);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule